// File: doc/BRIEF.md
# SPI Memory-Mapped Transaction Engine

This block is an SPI master (mode 0) that turns one request into one complete framed transaction for a peripheral with a 22-bit memory-mapped address space. A request names an operation, an address, up to four bytes of write data and a data byte count. The engine then drives chip select low, clocks out the header and the data, and raises chip select again. It reports the end of the frame with a single-cycle `rsp_done` pulse.

Reads and writes of 1, 2 or 4 bytes use the 32-bit request and response words, least significant byte first. Longer transfers stream. Write bytes beyond the fourth come from a show-ahead byte input that the engine acknowledges with `strm_take`. Every read data byte is also presented on `strm_rdata` with a one-cycle `strm_rvalid`. A host command is a fixed three-byte frame. The SCK half period is set by the `HALF_DIV` parameter.

Top module: `spi_mmio_engine`

## Requirements
- R1: After synchronous reset, `spi_cs_n` is 1, `spi_sck` is 0, `rsp_done` is 0 and `rsp_rdata` is 0.
- R2: SPI mode 0. SCK idles low and is low whenever chip select changes. MOSI changes only while SCK is low, and the bits of each byte go out most significant bit first.
- R3: A write (`req_op` = 1) starts with three address bytes: `{2'b10, addr[21:16]}`, then `addr[15:8]`, then `addr[7:0]`.
- R4: A read (`req_op` = 0) sends `{2'b00, addr[21:16]}`, `addr[15:8]`, `addr[7:0]`, one 0x00 dummy byte, and then 0x00 for every data byte it clocks in.
- R5: Data byte i (i < 4) of a write is `req_wdata[8i+7:8i]`. Read data byte i (i < 4) lands in `rsp_rdata[8i+7:8i]`. Lanes beyond the byte count read as 0.
- R6: A host command (`req_op` = 2 or 3) is exactly three bytes: `req_wdata[7:0]`, then 0x00, then 0x00.
- R7: Write data byte i for i >= 4 is the value on `strm_wdata` when the engine loads that byte. Each such load gives one `strm_take` pulse, so a count of N gives N-4 pulses.
- R8: Every read data byte, in order, appears on `strm_rdata` with a one-cycle `strm_rvalid` pulse.
- R9: `spi_cs_n` stays low for the whole frame, and the frame has exactly 8 x (frame byte count) SCK rising edges. The frame byte count is 4 + count for a read, 3 + count for a write, and 3 for a host command.
- R10: Between two frames, chip select stays high for at least 4 x `HALF_DIV` clock cycles, which is two SCK periods.
- R11: `rsp_done` is high for exactly one cycle. That cycle is the one after `spi_cs_n` goes high, and `rsp_rdata` holds the complete read result during it.
- R12: `req_start` is ignored while a frame or its chip-select high gap is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, accepted only when idle |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 host command |
| req_addr | input | ADDR_W | Device byte address |
| req_wdata | input | 32 | Write data (LSB first), or command byte in [7:0] |
| req_count | input | CNT_W | Number of data bytes |
| strm_wdata | input | 8 | Next streamed write byte (show-ahead) |
| strm_take | output | 1 | Streamed write byte consumed |
| rsp_rdata | output | 32 | Read data, first byte in [7:0] |
| rsp_done | output | 1 | One-cycle end-of-frame pulse |
| strm_rdata | output | 8 | Latest read data byte |
| strm_rvalid | output | 1 | `strm_rdata` valid pulse |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |

## Verification
The assertions assume the peripheral holds MISO steady around each SCK rising edge. They also assume the requester presents a fresh streamed write byte well before the next one is needed, about a full byte time later. The bench's slave model changes MISO only on SCK falling edges. Its stream source advances on the clock edge after each `strm_take`. Request fields are driven away from the clock edge and held stable while `req_start` is high, and every frame stays under 64 bytes so the slave's capture store never wraps.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_HOST  = 2'd2
  } spi_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } eng_state_e;

  localparam int unsigned HDR_WRITE = 3;
  localparam int unsigned HDR_READ  = 4;
  localparam int unsigned HOST_LEN  = 3;
  localparam int unsigned LANES     = 4;
  localparam int unsigned GAP_TICKS = 4;
endpackage

// File: rtl/spi_sck_tick.sv
module spi_sck_tick #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(HALF_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  input  logic       sample,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_byte <= '0;
    end else begin
      if (load)       tx_q <= load_byte;
      else if (shift) tx_q <= {tx_q[6:0], 1'b0};
      if (sample)     rx_byte <= {rx_byte[6:0], miso};
    end
  end

  assign mosi = tx_q[7];
endmodule

// File: rtl/spi_frame_builder.sv
module spi_frame_builder
  import spi_txn_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic [1:0]       op,
  input  logic [21:0]      addr,
  input  logic [31:0]      wdata,
  input  logic [7:0]       strm_byte,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       tx_byte,
  output logic             from_stream
);
  logic [IDX_W-1:0] data_pos;
  logic [7:0]       page;

  always_comb begin
    tx_byte     = 8'h00;
    from_stream = 1'b0;
    page        = {2'b00, addr[21:16]};
    data_pos    = idx - IDX_W'(HDR_WRITE);
    case (op)
      OP_WRITE: begin
        if (idx == IDX_W'(0))      tx_byte = page | 8'h80;
        else if (idx == IDX_W'(1)) tx_byte = addr[15:8];
        else if (idx == IDX_W'(2)) tx_byte = addr[7:0];
        else if (data_pos < IDX_W'(LANES)) tx_byte = wdata[8*data_pos[1:0] +: 8];
        else begin
          tx_byte     = strm_byte;
          from_stream = 1'b1;
        end
      end
      OP_READ: begin
        if (idx == IDX_W'(0))      tx_byte = page;
        else if (idx == IDX_W'(1)) tx_byte = addr[15:8];
        else if (idx == IDX_W'(2)) tx_byte = addr[7:0];
        else                       tx_byte = 8'h00;
      end
      default: begin
        tx_byte = (idx == IDX_W'(0)) ? wdata[7:0] : 8'h00;
      end
    endcase
  end
endmodule

// File: rtl/spi_mmio_engine.sv
module spi_mmio_engine
  import spi_txn_pkg::*;
#(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [7:0]        strm_wdata,
  output logic              strm_take,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_done,
  output logic [7:0]        strm_rdata,
  output logic              strm_rvalid,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned IDX_W    = CNT_W + 1;
  localparam int unsigned MIN_HIGH = GAP_TICKS * HALF_DIV;

  eng_state_e        state;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic [IDX_W-1:0]  total_q;
  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        bit_cnt;
  logic [2:0]        gap_cnt;
  logic              done_arm;
  logic              tick;
  logic              accept;
  logic [IDX_W-1:0]  nxt_idx;
  logic [7:0]        nxt_byte;
  logic              nxt_stream;
  logic [7:0]        rx_byte;
  logic [21:0]       addr_wide;
  logic              byte_end, last_byte, byte_advance;
  logic              shift_en, sample_en, load_en;
  logic              is_rd, rd_data_byte;
  logic [IDX_W-1:0]  rd_pos;
  logic [LANES-1:0]  lane_we;

  assign accept    = (state == ST_IDLE) && req_start;
  assign addr_wide = 22'(addr_q);
  assign nxt_idx   = (state == ST_LOAD) ? '0 : idx_q + 1'b1;
  assign is_rd     = (op_q == OP_READ);
  assign last_byte = (idx_q == total_q - 1'b1);
  assign byte_end  = (state == ST_SHIFT) && tick && spi_sck && (bit_cnt == 3'd7);
  assign byte_advance = byte_end && !last_byte;
  assign shift_en  = (state == ST_SHIFT) && tick && spi_sck && (bit_cnt != 3'd7);
  assign sample_en = (state == ST_SHIFT) && tick && !spi_sck;
  assign load_en   = (state == ST_LOAD) || byte_advance;
  assign rd_pos    = idx_q - IDX_W'(HDR_READ);
  assign rd_data_byte = is_rd && (idx_q >= IDX_W'(HDR_READ));

  spi_sck_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .tick    (tick)
  );

  spi_frame_builder #(.IDX_W(IDX_W)) u_build (
    .op          (op_q),
    .addr        (addr_wide),
    .wdata       (wdata_q),
    .strm_byte   (strm_wdata),
    .idx         (nxt_idx),
    .tx_byte     (nxt_byte),
    .from_stream (nxt_stream)
  );

  spi_bit_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load_en),
    .load_byte (nxt_byte),
    .shift     (shift_en),
    .sample    (sample_en),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte)
  );

  // Read result lanes: one byte register per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = byte_end && rd_data_byte &&
                        (rd_pos < IDX_W'(LANES)) && (rd_pos[1:0] == 2'(g));
    always_ff @(posedge clk) begin
      if (rst || accept)   rsp_rdata[8*g +: 8] <= 8'h00;
      else if (lane_we[g]) rsp_rdata[8*g +: 8] <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      op_q        <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      total_q     <= '0;
      idx_q       <= '0;
      bit_cnt     <= '0;
      gap_cnt     <= '0;
      spi_sck     <= 1'b0;
      spi_cs_n    <= 1'b1;
      done_arm    <= 1'b0;
      rsp_done    <= 1'b0;
      strm_take   <= 1'b0;
      strm_rvalid <= 1'b0;
      strm_rdata  <= '0;
    end else begin
      rsp_done    <= done_arm;
      done_arm    <= 1'b0;
      strm_take   <= 1'b0;
      strm_rvalid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_start) begin
            op_q    <= req_op;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            idx_q   <= '0;
            bit_cnt <= '0;
            case (req_op)
              OP_READ:  total_q <= IDX_W'(req_count) + IDX_W'(HDR_READ);
              OP_WRITE: total_q <= IDX_W'(req_count) + IDX_W'(HDR_WRITE);
              default:  total_q <= IDX_W'(HOST_LEN);
            endcase
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          spi_cs_n  <= 1'b0;
          strm_take <= nxt_stream;
          state     <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!spi_sck) begin
              spi_sck <= 1'b1;
            end else begin
              spi_sck <= 1'b0;
              if (bit_cnt == 3'd7) begin
                bit_cnt <= '0;
                if (rd_data_byte) begin
                  strm_rvalid <= 1'b1;
                  strm_rdata  <= rx_byte;
                end
                if (last_byte) begin
                  state <= ST_TAIL;
                end else begin
                  idx_q     <= idx_q + 1'b1;
                  strm_take <= nxt_stream;
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            spi_cs_n <= 1'b1;
            done_arm <= 1'b1;
            gap_cnt  <= '0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_cnt == 3'(GAP_TICKS - 1)) state <= ST_IDLE;
            else gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Chip-select high-time monitor used by the gap assertion
  logic [15:0] cs_high_cnt;
  always_ff @(posedge clk) begin
    if (rst)           cs_high_cnt <= '1;
    else if (spi_cs_n) cs_high_cnt <= (cs_high_cnt == '1) ? cs_high_cnt : cs_high_cnt + 1'b1;
    else               cs_high_cnt <= '0;
  end

  assert_sck_low_at_cs_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> !spi_sck);
  assert_mosi_steady_high_R2: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> $stable(spi_mosi));
  assert_sck_only_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> cs_high_cnt >= 16'(MIN_HIGH));
  assert_done_after_cs_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (spi_cs_n && $past(spi_cs_n)));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  assert_take_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    strm_take |-> !spi_cs_n);
  assert_rvalid_single_R8: assert property (@(posedge clk) disable iff (rst)
    strm_rvalid |=> !strm_rvalid);
endmodule

// File: tb/test_spi_mmio_engine.sv
module test_spi_mmio_engine;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic [1:0]  req_op = '0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  req_count = '0;
  logic [7:0]  strm_wdata;
  logic        strm_take;
  logic [31:0] rsp_rdata;
  logic        rsp_done;
  logic [7:0]  strm_rdata;
  logic        strm_rvalid;
  logic        sck, cs_n, mosi, miso;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  spi_mmio_engine #(.ADDR_W(22), .CNT_W(8), .HALF_DIV(HALF)) i_spi_mmio_engine (
    .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
    .strm_wdata(strm_wdata), .strm_take(strm_take), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .strm_rdata(strm_rdata), .strm_rvalid(strm_rvalid),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  function automatic logic [7:0] resp_byte(int k);
    return 8'(k * 29 + 8'h51);
  endfunction
  function automatic logic [7:0] sw_byte(int j);
    return 8'(j * 37 + 8'h0B);
  endfunction
  function automatic logic resp_bit(int p);
    logic [7:0] b;
    b = resp_byte(p / 8);
    return b[7 - (p % 8)];
  endfunction

  // Slave model: samples MOSI on SCK rise, drives MISO after SCK fall
  int rise_total = 0, rise_base = 0, fall_total = 0, fall_base = 0;
  logic [7:0] shreg = '0;
  logic [7:0] cap [64];
  always @(negedge cs_n) begin
    rise_base = rise_total;
    fall_base = fall_total;
  end
  always @(posedge sck) begin
    int n;
    shreg = {shreg[6:0], mosi};
    rise_total = rise_total + 1;
    n = rise_total - rise_base;
    if ((n % 8) == 0 && n / 8 <= 64) cap[n / 8 - 1] = shreg;
  end
  always @(negedge sck) fall_total = fall_total + 1;
  assign miso = resp_bit(fall_total - fall_base);

  // Stream sources and sinks
  int sw_ptr = 0, sw_base = 0, rv_total = 0, rv_base = 0, done_total = 0;
  logic [7:0] rv_cap [64];
  assign strm_wdata = sw_byte(sw_ptr - sw_base);
  always @(negedge clk) begin
    if (strm_take) sw_ptr = sw_ptr + 1;
    if (strm_rvalid) begin
      rv_cap[rv_total % 64] = strm_rdata;
      rv_total = rv_total + 1;
    end
    if (rsp_done) done_total = done_total + 1;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int frame_len(int op, int cnt);
    if (op == 0) return 4 + cnt;
    if (op == 1) return 3 + cnt;
    return 3;
  endfunction

  function automatic logic [7:0] exp_byte(int op, logic [21:0] a, logic [31:0] wd, int k);
    int i;
    if (op >= 2) return (k == 0) ? wd[7:0] : 8'h00;
    if (k == 0) return (op == 1) ? {2'b10, a[21:16]} : {2'b00, a[21:16]};
    if (k == 1) return a[15:8];
    if (k == 2) return a[7:0];
    if (op == 0) return 8'h00;
    i = k - 3;
    if (i < 4) return wd[8*i +: 8];
    return sw_byte(i - 4);
  endfunction

  function automatic logic [31:0] exp_rd(int cnt);
    logic [31:0] r = '0;
    for (int i = 0; i < 4 && i < cnt; i++) r[8*i +: 8] = resp_byte(4 + i);
    return r;
  endfunction

  task automatic issue(int op, logic [21:0] a, logic [31:0] wd, int cnt);
    @(negedge clk);
    req_op = 2'(op); req_addr = a; req_wdata = wd; req_count = 8'(cnt);
    sw_base = sw_ptr; rv_base = rv_total;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] rd);
    rd = 'x;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (rsp_done) begin
        rd = rsp_rdata;
        check("R11 cs high at done", 32'(cs_n), 32'd1);
        @(negedge clk);
        check("R11 done single cycle", 32'(rsp_done), 32'd0);
        return;
      end
    end
    check("R11 done seen", 32'd0, 32'd1);
  endtask

  task automatic verify_frame(string tag, int op, logic [21:0] a, logic [31:0] wd, int cnt);
    int len = frame_len(op, cnt);
    check("R9 sck rising edges", 32'(rise_total - rise_base), 32'(8 * len));
    for (int k = 0; k < len; k++) check(tag, 32'(cap[k]), 32'(exp_byte(op, a, wd, k)));
    check("R2 sck idle low", 32'(sck), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 cs_n after reset", 32'(cs_n), 32'd1);
    check("R1 sck after reset", 32'(sck), 32'd0);
    check("R1 done after reset", 32'(rsp_done), 32'd0);
    check("R1 rdata after reset", rsp_rdata, 32'd0);
  endtask

  task automatic t_write(logic [21:0] a, logic [31:0] wd, int cnt);
    logic [31:0] rd;
    issue(1, a, wd, cnt);
    wait_done(rd);
    repeat (4 * HALF + 4) @(negedge clk);
    verify_frame("R3 R5 write frame byte", 1, a, wd, cnt);
    check("R5 write leaves rdata zero", rd, 32'd0);
  endtask

  task automatic t_read(logic [21:0] a, int cnt);
    logic [31:0] rd;
    issue(0, a, 32'hDEAD_BEEF, cnt);
    wait_done(rd);
    repeat (4 * HALF + 4) @(negedge clk);
    verify_frame("R4 read frame byte", 0, a, 32'hDEAD_BEEF, cnt);
    check("R5 read data lanes", rd, exp_rd(cnt));
  endtask

  task automatic t_host(logic [7:0] cmd);
    logic [31:0] rd;
    issue(2, 22'h2A_5A5A, {24'hFFFFFF, cmd}, 9);
    wait_done(rd);
    repeat (4 * HALF + 4) @(negedge clk);
    verify_frame("R6 host command byte", 2, 22'h2A_5A5A, {24'hFFFFFF, cmd}, 9);
  endtask

  task automatic t_stream_write(int cnt);
    logic [31:0] rd;
    issue(1, 22'h01_2345, 32'h4433_2211, cnt);
    wait_done(rd);
    repeat (4 * HALF + 4) @(negedge clk);
    verify_frame("R7 streamed write byte", 1, 22'h01_2345, 32'h4433_2211, cnt);
    check("R7 take pulses", 32'(sw_ptr - sw_base), 32'(cnt - 4));
  endtask

  task automatic t_stream_read(int cnt);
    logic [31:0] rd;
    issue(0, 22'h3F_0F0F, 32'h0, cnt);
    wait_done(rd);
    repeat (4 * HALF + 4) @(negedge clk);
    check("R8 rvalid count", 32'(rv_total - rv_base), 32'(cnt));
    for (int i = 0; i < cnt; i++)
      check("R8 streamed read byte", 32'(rv_cap[(rv_base + i) % 64]), 32'(resp_byte(4 + i)));
    check("R5 low lanes of long read", rd, exp_rd(cnt));
  endtask

  task automatic t_ignore_start();
    logic [31:0] rd;
    int d0;
    d0 = done_total;
    issue(1, 22'h15_AA55, 32'h0000_C3A5, 2);
    repeat (30) @(negedge clk);
    req_op = 2'd0; req_addr = 22'h3F_FFFF; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    wait_done(rd);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (4 * HALF + 4) @(negedge clk);
    verify_frame("R12 frame unchanged by mid-frame start", 1, 22'h15_AA55, 32'h0000_C3A5, 2);
    repeat (60) @(negedge clk);
    check("R12 no extra frame", 32'(cs_n), 32'd1);
    check("R12 one done only", 32'(done_total - d0), 32'd1);
  endtask

  task automatic t_back_to_back();
    logic [31:0] rd;
    int gap;
    @(negedge clk);
    req_op = 2'd1; req_addr = 22'h22_1100; req_wdata = 32'h0000_0077; req_count = 8'd1;
    sw_base = sw_ptr;
    req_start = 1'b1;
    gap = 0;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (rsp_done) break;
    end
    for (int t = 0; t < 2000; t++) begin
      if (!cs_n) break;
      gap++;
      @(negedge clk);
    end
    req_start = 1'b0;
    check("R10 cs high gap cycles", 32'(gap + 1 >= 4 * HALF), 32'd1);
    wait_done(rd);
    repeat (4 * HALF + 4) @(negedge clk);
    verify_frame("R10 second frame byte", 1, 22'h22_1100, 32'h0000_0077, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(22'h3A_BCDE, 32'h1234_5678, 1);
    t_write(22'h00_0102, 32'h1234_5678, 2);
    t_write(22'h2F_FFFC, 32'hA1B2_C3D4, 4);
    t_read(22'h0C_0000, 1);
    t_read(22'h30_2468, 2);
    t_read(22'h1B_1357, 4);
    t_host(8'h68);
    t_stream_write(7);
    t_stream_read(6);
    t_ignore_start();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule